// File: doc/BRIEF.md
# Zero-Page and Stack Scratch Memory

This block is a 512-byte on-chip memory that holds the first two 256-byte pages of an 8-bit CPU's address space: page 0 for direct-page variables and pointers, and page 1 for the hardware stack. It has two ports that work in the same cycle. The pointer port fetches a 16-bit little-endian word. That word is either a return address popped from the stack or an indirect pointer held in page 0. The byte port reads or writes one byte at a time.

The byte port takes the full 16-bit operand address. A decoder checks whether that address falls in 0x0000 to 0x01FF. If it does, the access is served internally, and one cycle later a select flag tells the core to take operand data from this memory. If it does not, a forward request is raised toward the external bus. Writes into the two internal pages never produce a forward request, so they stay on chip. Reads on both ports return data one cycle after the request.

Top module: `zp_stack_ram`

## Requirements
- R1: While rst_ni is low and in the first cycle after reset, ptr_valid_o, sel_int_o, ptr_data_o and byte_rdata_o are all zero.
- R2: A byte read (byte_req_i=1, byte_we_i=0) whose address is below 0x0200 returns the last byte written there on byte_rdata_o one cycle later, with sel_int_o=1 in that cycle.
- R3: A byte request whose address is 0x0200 or above raises ext_req_o in the same cycle. It leaves internal storage unchanged, including the location with the same low 9 bits. In the next cycle sel_int_o=0 and byte_rdata_o=0.
- R4: A byte request whose address is below 0x0200 never raises ext_req_o, whether it reads or writes.
- R5: A pointer request (ptr_req_i=1) with page ptr_page_i (0 = page 0, 1 = page 1) and offset ptr_off_i returns, one cycle later, ptr_data_o[7:0] from offset ptr_off_i and ptr_data_o[15:8] from offset ptr_off_i+1 of the same page, with ptr_valid_o=1.
- R6: A page-0 pointer read at offset 0xFF takes its high byte from address 0x0000.
- R7: A page-1 pointer read at offset 0xFF takes its high byte from address 0x0100.
- R8: If the byte port writes an address in the same cycle that the pointer port reads it, the pointer port returns the data that was there before the write. A later read returns the new data.
- R9: A pointer read and a byte read issued in the same cycle both return correct data.
- R10: In a cycle after one with ptr_req_i=0, ptr_data_o keeps its previous value and ptr_valid_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ptr_req_i | input | 1 | Pointer read request |
| ptr_page_i | input | 1 | Pointer page: 0 = page 0, 1 = page 1 |
| ptr_off_i | input | 8 | Offset of the low byte within the page |
| ptr_data_o | output | 16 | Pointer word, high byte in [15:8] |
| ptr_valid_o | output | 1 | ptr_data_o was loaded this cycle |
| byte_req_i | input | 1 | Byte access request |
| byte_we_i | input | 1 | 1 = write, 0 = read |
| byte_addr_i | input | 16 | Full operand address |
| byte_wdata_i | input | 8 | Write data |
| byte_rdata_o | output | 8 | Read data, zero when sel_int_o is low |
| sel_int_o | output | 1 | Operand data comes from this memory |
| ext_req_o | output | 1 | Access must go to the external bus |

## Verification
Byte accesses are tried at addresses just below and at or above the 0x0200 boundary. They also include an external address that shares its low 9 bits with an internal location, which separates true redirect decoding from plain truncation of the address. Pointer reads at mid-page offsets are compared with reads at offset 0xFF in each page, which shows whether the high-byte increment wraps within the page or carries into the page number. A pointer read is issued in the same cycle as a byte write to the same location, which distinguishes read-before-write from write-through. A pointer read paired with a byte read in one cycle shows that the ports are independent. Idle cycles between requests show whether the pointer output holds its value.

// File: rtl/zsr_pkg.sv
package zsr_pkg;
  parameter int unsigned ADDR_W  = 16;
  parameter int unsigned DATA_W  = 8;
  parameter int unsigned OFF_W   = 8;
  parameter int unsigned PAGES   = 2;
  localparam int unsigned PAGE_W = $clog2(PAGES);
  localparam int unsigned IDX_W  = PAGE_W + OFF_W;
  localparam int unsigned DEPTH  = 1 << IDX_W;

  typedef logic [IDX_W-1:0]  idx_t;
  typedef logic [DATA_W-1:0] byte_t;

  typedef struct packed {
    byte_t hi;
    byte_t lo;
  } word_t;
endpackage

// File: rtl/zsr_decode.sv
module zsr_decode
  import zsr_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              req_i,
  output logic              hit_o,
  output idx_t              idx_o,
  output logic              ext_o
);
  // upper bits above the internal index must be zero to hit
  assign hit_o = (addr_i[ADDR_W-1:IDX_W] == '0);
  assign idx_o = addr_i[IDX_W-1:0];
  assign ext_o = req_i & ~hit_o;
endmodule

// File: rtl/zsr_ptr_addr.sv
module zsr_ptr_addr
  import zsr_pkg::*;
(
  input  logic [PAGE_W-1:0] page_i,
  input  logic [OFF_W-1:0]  off_i,
  output idx_t              lo_idx_o,
  output idx_t              hi_idx_o
);
  logic [OFF_W-1:0] off_nxt;

  // offset increment wraps inside the page, never carries into page bits
  assign off_nxt  = off_i + OFF_W'(1);
  assign lo_idx_o = {page_i, off_i};
  assign hi_idx_o = {page_i, off_nxt};
endmodule

// File: rtl/zsr_store.sv
module zsr_store
  import zsr_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  wr_en_i,
  input  idx_t  wr_idx_i,
  input  byte_t wr_data_i,
  input  logic  prd_en_i,
  input  idx_t  prd_lo_i,
  input  idx_t  prd_hi_i,
  output word_t prd_q_o,
  input  logic  brd_en_i,
  input  idx_t  brd_idx_i,
  output byte_t brd_q_o
);
  byte_t mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wr_idx_i] <= wr_data_i;
  end

  // registered reads see pre-write contents (read-before-write)
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prd_q_o <= '0;
      brd_q_o <= '0;
    end else begin
      if (prd_en_i) begin
        prd_q_o.lo <= mem_q[prd_lo_i];
        prd_q_o.hi <= mem_q[prd_hi_i];
      end
      if (brd_en_i) brd_q_o <= mem_q[brd_idx_i];
    end
  end
endmodule

// File: rtl/zp_stack_ram.sv
module zp_stack_ram
  import zsr_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 ptr_req_i,
  input  logic [PAGE_W-1:0]    ptr_page_i,
  input  logic [OFF_W-1:0]     ptr_off_i,
  output logic [2*DATA_W-1:0]  ptr_data_o,
  output logic                 ptr_valid_o,
  input  logic                 byte_req_i,
  input  logic                 byte_we_i,
  input  logic [ADDR_W-1:0]    byte_addr_i,
  input  logic [DATA_W-1:0]    byte_wdata_i,
  output logic [DATA_W-1:0]    byte_rdata_o,
  output logic                 sel_int_o,
  output logic                 ext_req_o
);
  logic  hit;
  idx_t  b_idx, p_lo, p_hi;
  word_t p_q;
  byte_t b_q;
  logic  wr_en, brd_en;

  zsr_decode u_dec (
    .addr_i (byte_addr_i),
    .req_i  (byte_req_i),
    .hit_o  (hit),
    .idx_o  (b_idx),
    .ext_o  (ext_req_o)
  );

  zsr_ptr_addr u_pa (
    .page_i   (ptr_page_i),
    .off_i    (ptr_off_i),
    .lo_idx_o (p_lo),
    .hi_idx_o (p_hi)
  );

  assign wr_en  = byte_req_i & byte_we_i & hit;
  assign brd_en = byte_req_i & ~byte_we_i & hit;

  zsr_store u_mem (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en),
    .wr_idx_i  (b_idx),
    .wr_data_i (byte_wdata_i),
    .prd_en_i  (ptr_req_i),
    .prd_lo_i  (p_lo),
    .prd_hi_i  (p_hi),
    .prd_q_o   (p_q),
    .brd_en_i  (brd_en),
    .brd_idx_i (b_idx),
    .brd_q_o   (b_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_valid_o <= 1'b0;
      sel_int_o   <= 1'b0;
    end else begin
      ptr_valid_o <= ptr_req_i;
      sel_int_o   <= brd_en;
    end
  end

  assign ptr_data_o   = p_q;
  assign byte_rdata_o = sel_int_o ? b_q : '0;
endmodule

// File: rtl/zsr_checker.sv
module zsr_checker
  import zsr_pkg::*;
(
  input logic                clk_i,
  input logic                rst_ni,
  input logic                ptr_req_i,
  input logic [2*DATA_W-1:0] ptr_data_o,
  input logic                ptr_valid_o,
  input logic                byte_req_i,
  input logic                byte_we_i,
  input logic [ADDR_W-1:0]   byte_addr_i,
  input logic                sel_int_o,
  input logic                ext_req_o
);
  logic low_addr;
  assign low_addr = (byte_addr_i < ADDR_W'(DEPTH));

  AST_SEL_ON_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_req_i && !byte_we_i && low_addr) |=> sel_int_o); // R2
  AST_NO_SEL_OTHER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(byte_req_i && !byte_we_i && low_addr) |=> !sel_int_o); // R3
  AST_EXT_ON_MISS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_req_i && !low_addr) |-> ext_req_o); // R3
  AST_NO_FORWARD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_req_i && low_addr) |-> !ext_req_o); // R4
  AST_PTR_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_req_i |=> ptr_valid_o); // R5
  AST_PTR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ptr_req_i |=> (!ptr_valid_o && $stable(ptr_data_o))); // R10
endmodule

bind zp_stack_ram zsr_checker u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ptr_req_i   (ptr_req_i),
  .ptr_data_o  (ptr_data_o),
  .ptr_valid_o (ptr_valid_o),
  .byte_req_i  (byte_req_i),
  .byte_we_i   (byte_we_i),
  .byte_addr_i (byte_addr_i),
  .sel_int_o   (sel_int_o),
  .ext_req_o   (ext_req_o)
);

// File: tb/zp_stack_ram_tb_top.sv
module zp_stack_ram_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ptr_req_i = 1'b0;
  logic [0:0]  ptr_page_i = '0;
  logic [7:0]  ptr_off_i = '0;
  logic [15:0] ptr_data_o;
  logic        ptr_valid_o;
  logic        byte_req_i = 1'b0;
  logic        byte_we_i = 1'b0;
  logic [15:0] byte_addr_i = '0;
  logic [7:0]  byte_wdata_i = '0;
  logic [7:0]  byte_rdata_o;
  logic        sel_int_o;
  logic        ext_req_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  zp_stack_ram dut_i (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    ptr_req_i = 1'b0; byte_req_i = 1'b0; byte_we_i = 1'b0;
  endtask

  // drive at negedge, clock once, then sample after the edge
  task automatic step();
    @(posedge clk_i); #1;
    @(negedge clk_i);
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    idle();
    byte_req_i = 1'b1; byte_we_i = 1'b1; byte_addr_i = a; byte_wdata_i = d;
    step(); idle();
  endtask

  task automatic t_reset();
    chk("R1 ptr_valid", 32'(ptr_valid_o), 0);
    chk("R1 sel_int", 32'(sel_int_o), 0);
    chk("R1 ptr_data", 32'(ptr_data_o), 0);
    chk("R1 byte_rdata", 32'(byte_rdata_o), 0);
  endtask

  task automatic t_byte_rw();
    wr(16'h0042, 8'h3C);
    wr(16'h01FF, 8'hE7);
    byte_req_i = 1'b1; byte_addr_i = 16'h0042; #1;
    chk("R4 read no forward", 32'(ext_req_o), 0);
    step();
    chk("R2 rdata", 32'(byte_rdata_o), 32'h3C);
    chk("R2 sel", 32'(sel_int_o), 1);
    byte_addr_i = 16'h01FF; step();
    chk("R2 rdata top", 32'(byte_rdata_o), 32'hE7);
    idle();
  endtask

  task automatic t_miss();
    wr(16'h0005, 8'hA5);
    byte_req_i = 1'b1; byte_we_i = 1'b1; byte_addr_i = 16'h0005; byte_wdata_i = 8'hA5; #1;
    chk("R4 internal write not forwarded", 32'(ext_req_o), 0);
    byte_addr_i = 16'h0205; byte_wdata_i = 8'h5A; #1;
    chk("R3 ext_req on write miss", 32'(ext_req_o), 1);
    step();
    byte_we_i = 1'b0; byte_addr_i = 16'h0200; #1;
    chk("R3 ext_req on read miss", 32'(ext_req_o), 1);
    step();
    chk("R3 sel low", 32'(sel_int_o), 0);
    chk("R3 rdata zero", 32'(byte_rdata_o), 0);
    byte_addr_i = 16'h0005; step();
    chk("R3 alias unchanged", 32'(byte_rdata_o), 32'hA5);
    idle();
  endtask

  task automatic ptr_rd(input logic pg, input logic [7:0] off);
    idle();
    ptr_req_i = 1'b1; ptr_page_i = pg; ptr_off_i = off;
    step(); idle();
  endtask

  task automatic t_ptr();
    wr(16'h0020, 8'h34); wr(16'h0021, 8'h12);
    ptr_rd(1'b0, 8'h20);
    chk("R5 zp pointer", 32'(ptr_data_o), 32'h1234);
    chk("R5 valid", 32'(ptr_valid_o), 1);
    wr(16'h0180, 8'hCD); wr(16'h0181, 8'hAB);
    ptr_rd(1'b1, 8'h80);
    chk("R5 stack pointer", 32'(ptr_data_o), 32'hABCD);
  endtask

  task automatic t_wrap();
    wr(16'h00FF, 8'h77); wr(16'h0000, 8'h66); wr(16'h0100, 8'h55);
    ptr_rd(1'b0, 8'hFF);
    chk("R6 zp wrap", 32'(ptr_data_o), 32'h6677);
    ptr_rd(1'b1, 8'hFF);
    chk("R7 stack wrap", 32'(ptr_data_o), 32'h55E7);
  endtask

  task automatic t_collide();
    wr(16'h0010, 8'h11); wr(16'h0011, 8'h22);
    ptr_req_i = 1'b1; ptr_page_i = 1'b0; ptr_off_i = 8'h10;
    byte_req_i = 1'b1; byte_we_i = 1'b1; byte_addr_i = 16'h0010; byte_wdata_i = 8'h99;
    step(); idle();
    chk("R8 old data", 32'(ptr_data_o), 32'h2211);
    ptr_rd(1'b0, 8'h10);
    chk("R8 new data", 32'(ptr_data_o), 32'h2299);
  endtask

  task automatic t_dual();
    ptr_req_i = 1'b1; ptr_page_i = 1'b0; ptr_off_i = 8'h20;
    byte_req_i = 1'b1; byte_we_i = 1'b0; byte_addr_i = 16'h0181;
    step(); idle();
    chk("R9 ptr side", 32'(ptr_data_o), 32'h1234);
    chk("R9 byte side", 32'(byte_rdata_o), 32'hAB);
  endtask

  task automatic t_hold();
    ptr_rd(1'b1, 8'h80);
    step();
    chk("R10 hold data", 32'(ptr_data_o), 32'hABCD);
    chk("R10 valid low", 32'(ptr_valid_o), 0);
    step();
    chk("R10 hold data again", 32'(ptr_data_o), 32'hABCD);
  endtask

  initial begin
    #1;
    t_reset();
    repeat (3) @(posedge clk_i);
    @(negedge clk_i); rst_ni = 1'b1;
    step();
    t_reset();
    t_byte_rw();
    t_miss();
    t_ptr();
    t_wrap();
    t_collide();
    t_dual();
    t_hold();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule